// File: doc/BRIEF.md
# Multi-Mode Video Line Scheduler

This block turns a fast hardware process clock into a fixed schedule of machine cycles and groups them into process cycles of twenty machine cycles each. A process cycle is laid out either as four scan lines of five machine cycles or as five scan lines of four machine cycles. The arrangement depends on which of four display timings is selected. The last machine cycle of every scan line is a timing slot. In that slot the block drives horizontal sync and steps the line the renderer should draw next. Vertical sync comes from a per-timing window over the line count of the field.

The machine cycles that are not timing slots go to user code on a virtual CPU. The exception is the first few of each process cycle, which are reserved when the serial or audio features are switched on: one slot for serial, one for the audio state, and one per voice for up to four voices. The slot kind is presented on every clock, and a one-clock strobe marks the start of each machine cycle, so the units downstream know whose turn it is. A 7-bit mode word selects the timing and the vertical line-repeat divisor. It also carries two renderer control bits, and the block derives a third.

Top module: `vls_line_scheduler`

## Requirements
- R1: A machine cycle lasts CLKS_PER_MC clocks (default 43). `mc_start_o` is high on its first clock only, and `slot_kind_o` and `voice_idx_o` stay constant for the whole machine cycle.
- R2: Mode bits [1:0] pick the timing: 0 = 75 Hz VGA-like, 1 = SVGA-like, 2 = XGA-like, 3 = reduced-blanking. Timings 0 and 1 use 4 lines of 5 machine cycles per process cycle, and timings 2 and 3 use 5 lines of 4. A field is 128 process cycles for timing 0 (512 lines) and 160 process cycles for the others (640 lines for timing 1, 800 for timings 2 and 3).
- R3: The last machine cycle of every line is a timing slot (`slot_kind_o` = 1), and `hsync_o` is high exactly during timing slots.
- R4: At the start of the timing slot of field line s, `render_line_o` becomes ((s+1) mod T)/D, where T is the number of lines in the field and D is the divisor. It holds that value otherwise, and it is 0 after reset.
- R5: Mode bits [4:2] select D as 2, 3, 4, 5, 6, 8, 10 or 16 for codes 0 to 7. In timings 2 and 3, code 0 falls back to 3 and code 3 falls back to 4.
- R6: `vsync_o` is high for the field lines [481,484) in timing 0, [601,605) in timing 1, [771,777) in timing 2 and [780,788) in timing 3.
- R7: Counting only non-timing machine cycles from the start of each process cycle, the first ones are reserved in this order: serial (kind 2) if serial is enabled; then, if audio is enabled, the audio state (kind 3) followed by one voice slot per voice (kind 4, `voice_idx_o` 0 upward). The voice count is clamped to 4 and is ignored while audio is off. All other non-timing cycles are user cycles (kind 0, `voice_idx_o` 0).
- R8: The feature inputs are sampled on the first clock of each process cycle, and the mode on the first clock of each field. A change made at any other time has no effect until that point.
- R9: `gpu_fetch2_o` follows mode bit 5 and `gpu_dac256_o` follows mode bit 6. `gpu_rb_o` is high only in timing 3.
- R10: While reset is held, every output is 0. The first clock after release is the first clock of a field, with `mc_start_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Hardware process clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 7 | Mode word: [1:0] timing, [4:2] divisor code, [5] two-cycle fetch, [6] 256-colour DAC |
| serial_en_i | input | 1 | Reserve a serial slot per process cycle |
| audio_en_i | input | 1 | Reserve audio state and voice slots |
| voices_i | input | 3 | Number of audio voices (clamped to 4) |
| mc_start_o | output | 1 | First clock of a machine cycle |
| slot_kind_o | output | 3 | 0 user, 1 timing, 2 serial, 3 audio state, 4 voice |
| voice_idx_o | output | 2 | Voice served by a voice slot |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| render_line_o | output | 10 | Line index the renderer draws next |
| gpu_fetch2_o | output | 1 | Two-cycle (graphics) fetch selected |
| gpu_dac256_o | output | 1 | 256-colour DAC selected |
| gpu_rb_o | output | 1 | Reduced blanking active |

## Verification
On every cycle the assertions check the following: the machine-cycle period and steady slot kinds; that hsync and timing slots coincide; that the render line, vsync and renderer controls change only at the machine-cycle boundaries where they are allowed to; and that the slot encodings are legal. Only the bench's scenarios can show that the values are right. That covers the exact vsync windows, the render line under each divisor and its fallbacks, the order and count of reserved slots, the voice clamp, and the deferral of mode and feature changes to field and process-cycle boundaries.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int unsigned MAX_LINES = 800;
  localparam int unsigned LINE_W    = $clog2(MAX_LINES);
  localparam int unsigned PC_W      = 8;
  localparam int unsigned FREE_W    = 4;
  localparam int unsigned REP_W     = 5;

  typedef enum logic [1:0] {
    TM_VGA75  = 2'd0,
    TM_SVGA60 = 2'd1,
    TM_XGA60  = 2'd2,
    TM_RBLANK = 2'd3
  } timing_e;

  typedef enum logic [2:0] {
    SLOT_USER   = 3'd0,
    SLOT_TIMING = 3'd1,
    SLOT_SERIAL = 3'd2,
    SLOT_AUDIO  = 3'd3,
    SLOT_VOICE  = 3'd4
  } slot_e;

  typedef struct packed {
    logic       dac256;
    logic       fetch2;
    logic [2:0] div_code;
    timing_e    timing;
  } mode_t;

  typedef struct packed {
    logic       serial;
    logic       audio;
    logic [2:0] voices;
  } feat_t;

  function automatic logic five_line(timing_e t);
    return t[1];
  endfunction

  function automatic logic [2:0] lines_per_pc(timing_e t);
    return five_line(t) ? 3'd5 : 3'd4;
  endfunction

  function automatic logic [2:0] mcs_per_line(timing_e t);
    return five_line(t) ? 3'd4 : 3'd5;
  endfunction

  function automatic logic [PC_W-1:0] pcs_per_field(timing_e t);
    return (t == TM_VGA75) ? PC_W'(128) : PC_W'(160);
  endfunction

  function automatic logic [LINE_W-1:0] field_lines(timing_e t);
    case (t)
      TM_VGA75:  return LINE_W'(512);
      TM_SVGA60: return LINE_W'(640);
      default:   return LINE_W'(800);
    endcase
  endfunction

  function automatic logic [LINE_W-1:0] vs_first(timing_e t);
    case (t)
      TM_VGA75:  return LINE_W'(481);
      TM_SVGA60: return LINE_W'(601);
      TM_XGA60:  return LINE_W'(771);
      default:   return LINE_W'(780);
    endcase
  endfunction

  function automatic logic [3:0] vs_len(timing_e t);
    case (t)
      TM_VGA75:  return 4'd3;
      TM_SVGA60: return 4'd4;
      TM_XGA60:  return 4'd6;
      default:   return 4'd8;
    endcase
  endfunction

  // 5-line timings cannot fit divisors 2 and 5; map to nearest legal value.
  function automatic logic [REP_W-1:0] line_repeat(timing_e t, logic [2:0] code);
    case (code)
      3'd0:    return five_line(t) ? REP_W'(3) : REP_W'(2);
      3'd1:    return REP_W'(3);
      3'd2:    return REP_W'(4);
      3'd3:    return five_line(t) ? REP_W'(4) : REP_W'(5);
      3'd4:    return REP_W'(6);
      3'd5:    return REP_W'(8);
      3'd6:    return REP_W'(10);
      default: return REP_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/vls_mc_timer.sv
module vls_mc_timer #(
  parameter int unsigned CLKS_PER_MC = 43
) (
  input  logic clk,
  input  logic rst_n,
  output logic mc_first_o,
  output logic mc_last_o
);
  localparam int unsigned CW = $clog2(CLKS_PER_MC);

  logic [CW-1:0] cnt_q;

  assign mc_first_o = (cnt_q == '0);
  assign mc_last_o  = (cnt_q == CW'(CLKS_PER_MC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (mc_last_o) cnt_q <= '0;
    else                cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/vls_line_seq.sv
module vls_line_seq
  import vls_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mc_last,
  input  logic [2:0]            mc_per_line,
  input  logic [2:0]            lines_per_pc,
  input  logic [PC_W-1:0]       pcs_per_field,
  output logic                  timing_slot_o,
  output logic                  pc_zero_o,
  output logic                  field_zero_o,
  output logic [FREE_W-1:0]     free_idx_o,
  output logic [LINE_W-1:0]     scan_idx_o
);
  logic [2:0]        mc_q;
  logic [2:0]        line_q;
  logic [PC_W-1:0]   pc_q;
  logic [FREE_W-1:0] free_q;
  logic [LINE_W-1:0] scan_q;
  logic              end_line, end_pc, end_field;

  assign timing_slot_o = (mc_q == mc_per_line - 3'd1);
  assign end_line      = mc_last && timing_slot_o;
  assign end_pc        = end_line && (line_q == lines_per_pc - 3'd1);
  assign end_field     = end_pc && (pc_q == pcs_per_field - PC_W'(1));

  assign pc_zero_o     = (mc_q == 3'd0) && (line_q == 3'd0);
  assign field_zero_o  = pc_zero_o && (pc_q == '0);
  assign free_idx_o    = free_q;
  assign scan_idx_o    = scan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q   <= '0;
      line_q <= '0;
      pc_q   <= '0;
      free_q <= '0;
      scan_q <= '0;
    end else begin
      if (mc_last)  mc_q <= end_line ? 3'd0 : mc_q + 3'd1;
      if (end_line) begin
        line_q <= end_pc ? 3'd0 : line_q + 3'd1;
        scan_q <= end_field ? '0 : scan_q + LINE_W'(1);
      end
      if (end_pc)   pc_q <= end_field ? '0 : pc_q + PC_W'(1);
      if (end_pc)                            free_q <= '0;
      else if (mc_last && !timing_slot_o)    free_q <= free_q + FREE_W'(1);
    end
  end
endmodule

// File: rtl/vls_slot_alloc.sv
module vls_slot_alloc
  import vls_pkg::*;
(
  input  logic              timing_slot,
  input  logic [FREE_W-1:0] free_idx,
  input  feat_t             feat,
  output slot_e             kind_o,
  output logic [1:0]        voice_idx_o
);
  logic [FREE_W-1:0] audio_base;
  logic [FREE_W-1:0] n_voice;
  logic [FREE_W-1:0] voice_off;

  always_comb begin
    audio_base = feat.serial ? FREE_W'(1) : FREE_W'(0);
    if (!feat.audio)            n_voice = '0;
    else if (feat.voices > 3'd4) n_voice = FREE_W'(4);
    else                        n_voice = FREE_W'(feat.voices);
    voice_off   = free_idx - audio_base - FREE_W'(1);
    kind_o      = SLOT_USER;
    voice_idx_o = 2'd0;
    if (timing_slot) begin
      kind_o = SLOT_TIMING;
    end else if (feat.serial && free_idx == '0) begin
      kind_o = SLOT_SERIAL;
    end else if (feat.audio && free_idx == audio_base) begin
      kind_o = SLOT_AUDIO;
    end else if (feat.audio && free_idx > audio_base &&
                 free_idx <= audio_base + n_voice) begin
      kind_o      = SLOT_VOICE;
      voice_idx_o = voice_off[1:0];
    end
  end
endmodule

// File: rtl/vls_vtiming.sv
module vls_vtiming
  import vls_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  timing_e           timing,
  input  logic [REP_W-1:0]  repeat_n,
  input  logic [LINE_W-1:0] scan_idx,
  input  logic              line_step,
  output logic              vsync_o,
  output logic [LINE_W-1:0] render_o
);
  logic [REP_W-1:0] rep_q;
  logic [LINE_W:0]  scan_x, vs_lo, vs_hi;
  logic             last_line, in_vs;

  assign last_line = (scan_idx == field_lines(timing) - LINE_W'(1));
  assign scan_x    = {1'b0, scan_idx};
  assign vs_lo     = {1'b0, vs_first(timing)};
  assign vs_hi     = vs_lo + (LINE_W+1)'(vs_len(timing));
  assign in_vs     = (scan_x >= vs_lo) && (scan_x < vs_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsync_o  <= 1'b0;
      render_o <= '0;
      rep_q    <= '0;
    end else begin
      vsync_o <= in_vs;
      if (line_step) begin
        if (last_line) begin
          rep_q    <= '0;
          render_o <= '0;
        end else if (rep_q == repeat_n - REP_W'(1)) begin
          rep_q    <= '0;
          render_o <= render_o + LINE_W'(1);
        end else begin
          rep_q    <= rep_q + REP_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/vls_line_scheduler.sv
module vls_line_scheduler
  import vls_pkg::*;
#(
  parameter int unsigned CLKS_PER_MC = 43
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        mode_i,
  input  logic              serial_en_i,
  input  logic              audio_en_i,
  input  logic [2:0]        voices_i,
  output logic              mc_start_o,
  output logic [2:0]        slot_kind_o,
  output logic [1:0]        voice_idx_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic [LINE_W-1:0] render_line_o,
  output logic              gpu_fetch2_o,
  output logic              gpu_dac256_o,
  output logic              gpu_rb_o
);
  logic              mc_first, mc_last;
  logic              timing_slot, pc_zero, field_zero;
  logic [FREE_W-1:0] free_idx;
  logic [LINE_W-1:0] scan_idx;
  mode_t             mode_q, mode_eff;
  feat_t             feat_q, feat_in, feat_eff;
  slot_e             kind;
  logic [1:0]        voice_idx;

  vls_mc_timer #(.CLKS_PER_MC(CLKS_PER_MC)) u_mc_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .mc_first_o (mc_first),
    .mc_last_o  (mc_last)
  );

  // Capture points: mode at field start, features at process-cycle start.
  assign feat_in  = '{serial: serial_en_i, audio: audio_en_i, voices: voices_i};
  assign mode_eff = (mc_first && field_zero) ? mode_t'(mode_i) : mode_q;
  assign feat_eff = (mc_first && pc_zero) ? feat_in : feat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      feat_q <= '0;
    end else begin
      mode_q <= mode_eff;
      feat_q <= feat_eff;
    end
  end

  vls_line_seq u_line_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .mc_last       (mc_last),
    .mc_per_line   (mcs_per_line(mode_eff.timing)),
    .lines_per_pc  (lines_per_pc(mode_eff.timing)),
    .pcs_per_field (pcs_per_field(mode_eff.timing)),
    .timing_slot_o (timing_slot),
    .pc_zero_o     (pc_zero),
    .field_zero_o  (field_zero),
    .free_idx_o    (free_idx),
    .scan_idx_o    (scan_idx)
  );

  vls_slot_alloc u_slot_alloc (
    .timing_slot (timing_slot),
    .free_idx    (free_idx),
    .feat        (feat_eff),
    .kind_o      (kind),
    .voice_idx_o (voice_idx)
  );

  vls_vtiming u_vtiming (
    .clk       (clk),
    .rst_n     (rst_n),
    .timing    (mode_eff.timing),
    .repeat_n  (line_repeat(mode_eff.timing, mode_eff.div_code)),
    .scan_idx  (scan_idx),
    .line_step (mc_first && timing_slot),
    .vsync_o   (vsync_o),
    .render_o  (render_line_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_start_o   <= 1'b0;
      slot_kind_o  <= SLOT_USER;
      voice_idx_o  <= 2'd0;
      hsync_o      <= 1'b0;
      gpu_fetch2_o <= 1'b0;
      gpu_dac256_o <= 1'b0;
      gpu_rb_o     <= 1'b0;
    end else begin
      mc_start_o   <= mc_first;
      slot_kind_o  <= kind;
      voice_idx_o  <= voice_idx;
      hsync_o      <= timing_slot;
      gpu_fetch2_o <= mode_eff.fetch2;
      gpu_dac256_o <= mode_eff.dac256;
      gpu_rb_o     <= (mode_eff.timing == TM_RBLANK);
    end
  end
endmodule

// File: rtl/vls_line_scheduler_sva.sv
module vls_line_scheduler_sva #(
  parameter int unsigned CLKS_PER_MC = 43
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mc_start,
  input logic [2:0] slot_kind,
  input logic [1:0] voice_idx,
  input logic       hsync,
  input logic       vsync,
  input logic [9:0] render_line,
  input logic [2:0] gpu_bits
);
  logic        started, seen_start;
  logic [15:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started    <= 1'b0;
      seen_start <= 1'b0;
      gap_q      <= '0;
    end else begin
      started <= 1'b1;
      if (mc_start) begin
        seen_start <= 1'b1;
        gap_q      <= '0;
      end else begin
        gap_q <= gap_q + 16'd1;
      end
    end
  end

  AST_MC_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_start && seen_start) |-> (gap_q == 16'(CLKS_PER_MC - 1)));  // R1
  AST_SLOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !mc_start) |-> ($stable(slot_kind) && $stable(voice_idx)));  // R1
  AST_HSYNC_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    hsync == (slot_kind == 3'd1));  // R3
  AST_RENDER_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !$stable(render_line)) |-> (mc_start && slot_kind == 3'd1));  // R4
  AST_VSYNC_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !$stable(vsync)) |-> (mc_start && $past(slot_kind) == 3'd1));  // R6
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    slot_kind <= 3'd4);  // R7
  AST_VOICE_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_kind != 3'd4) |-> (voice_idx == 2'd0));  // R7
  AST_GPU_AT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !$stable(gpu_bits)) |-> (mc_start && $past(slot_kind) == 3'd1));  // R8
endmodule

bind vls_line_scheduler vls_line_scheduler_sva #(.CLKS_PER_MC(CLKS_PER_MC)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .mc_start    (mc_start_o),
  .slot_kind   (slot_kind_o),
  .voice_idx   (voice_idx_o),
  .hsync       (hsync_o),
  .vsync       (vsync_o),
  .render_line (render_line_o),
  .gpu_bits    ({gpu_fetch2_o, gpu_dac256_o, gpu_rb_o})
);

// File: tb/vls_line_scheduler_tb_top.sv
module vls_line_scheduler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MC_CLKS    = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] mode_i = '0;
  logic       serial_en_i = 1'b0, audio_en_i = 1'b0;
  logic [2:0] voices_i = '0;
  logic       mc_start_o, hsync_o, vsync_o, gpu_fetch2_o, gpu_dac256_o, gpu_rb_o;
  logic [2:0] slot_kind_o;
  logic [1:0] voice_idx_o;
  logic [9:0] render_line_o;

  int checks = 0, fails = 0;
  bit chk_on = 0, done = 0;

  vls_line_scheduler #(.CLKS_PER_MC(MC_CLKS)) dut_i (
    .clk, .rst_n, .mode_i, .serial_en_i, .audio_en_i, .voices_i,
    .mc_start_o, .slot_kind_o, .voice_idx_o, .hsync_o, .vsync_o,
    .render_line_o, .gpu_fetch2_o, .gpu_dac256_o, .gpu_rb_o);

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference tables, written from the requirements.
  int lines_t[4] = '{512, 640, 800, 800};
  int pcs_t[4]   = '{128, 160, 160, 160};
  int vs0_t[4]   = '{481, 601, 771, 780};
  int vsn_t[4]   = '{3, 4, 6, 8};
  int div4[8]    = '{2, 3, 4, 5, 6, 8, 10, 16};
  int div5[8]    = '{3, 3, 4, 4, 6, 8, 10, 16};

  int c, m, ln, p;
  int md, f_ser, f_aud, f_voc;
  int e_start, e_kind, e_vidx, e_hs, e_vs, e_rl, e_f2, e_d256, e_rb;
  bit tag_fb;

  always @(posedge clk) begin
    if (!rst_n) begin
      c = 0; m = 0; ln = 0; p = 0; md = 0; f_ser = 0; f_aud = 0; f_voc = 0;
      e_start = 0; e_kind = 0; e_vidx = 0; e_hs = 0; e_vs = 0; e_rl = 0;
      e_f2 = 0; e_d256 = 0; e_rb = 0; tag_fb = 0;
    end else begin
      int t, L, N, T, D, scan, fo, nv;
      int q[$];
      if (c == 0 && m == 0 && ln == 0 && p == 0) md = int'(mode_i);
      if (c == 0 && m == 0 && ln == 0) begin
        f_ser = serial_en_i; f_aud = audio_en_i; f_voc = voices_i;
      end
      t = md % 4;
      N = (t >= 2) ? 5 : 4;
      L = 20 / N;
      T = lines_t[t];
      D = (t >= 2) ? div5[(md / 4) % 8] : div4[(md / 4) % 8];
      tag_fb = (t >= 2) && (((md / 4) % 8) == 0 || ((md / 4) % 8) == 3);
      scan = p * N + ln;
      e_start = (c == 0);
      e_hs = (m == L - 1);
      e_vs = (scan >= vs0_t[t]) && (scan < vs0_t[t] + vsn_t[t]);
      e_f2 = (md / 32) % 2; e_d256 = (md / 64) % 2; e_rb = (t == 3);
      if (e_hs && c == 0) e_rl = ((scan + 1) % T) / D;
      q = {};
      if (f_ser) q.push_back(2);
      if (f_aud) begin
        nv = (f_voc > 4) ? 4 : f_voc;
        q.push_back(3);
        for (int i = 0; i < nv; i++) q.push_back(4);
      end
      fo = ln * (L - 1) + m;
      e_vidx = 0;
      if (e_hs) e_kind = 1;
      else if (fo < q.size()) begin
        e_kind = q[fo];
        if (e_kind == 4) e_vidx = fo - f_ser - 1;
      end else e_kind = 0;
      c++;
      if (c == MC_CLKS) begin
        c = 0; m++;
        if (m == L) begin
          m = 0; ln++;
          if (ln == N) begin
            ln = 0; p++;
            if (p == pcs_t[t]) p = 0;
          end
        end
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      bit rs;
      rs = !rst_n;
      chk(rs ? "R10" : "R1", "mc_start", int'(mc_start_o), e_start);
      chk(rs ? "R10" : ((e_kind <= 1) ? "R2" : "R7"), "slot_kind", int'(slot_kind_o), e_kind);
      chk(rs ? "R10" : "R7", "voice_idx", int'(voice_idx_o), e_vidx);
      chk(rs ? "R10" : "R3", "hsync", int'(hsync_o), e_hs);
      chk(rs ? "R10" : "R6", "vsync", int'(vsync_o), e_vs);
      chk(rs ? "R10" : (tag_fb ? "R5" : "R4"), "render_line", int'(render_line_o), e_rl);
      chk(rs ? "R10" : "R9", "gpu_bits",
          int'({gpu_fetch2_o, gpu_dac256_o, gpu_rb_o}), e_f2 * 4 + e_d256 * 2 + e_rb);
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // R10: reset state
    mode_i = 7'b0_0_000_00;
    wait_clk(2);
    chk_on = 1;
    wait_clk(3);
    rst_n = 1'b1;
    // VGA-like, divisor 2, serial switched on mid process cycle (R7, R8)
    wait_clk(2017);
    serial_en_i = 1'b1;
    wait_clk(7000);
    // R8: mode change mid-field must not reach the outputs yet
    audio_en_i = 1'b1; voices_i = 3'd2;
    mode_i = {1'b0, 1'b1, 3'd7, 2'd1};
    wait_clk(5);
    chk("R8", "gpu_fetch2 before field end", int'(gpu_fetch2_o), 0);
    wait_clk(12000);
    // XGA-like with divisor code 0 (falls back to 3), voices clamped (R5, R7)
    mode_i = {1'b0, 1'b0, 3'd0, 2'd2};
    voices_i = 3'd7;
    wait_clk(12000);
    // Reduced blanking, code 3 (falls back to 4), voices ignored with audio off
    mode_i = {1'b1, 1'b0, 3'd3, 2'd3};
    audio_en_i = 1'b0; serial_en_i = 1'b0; voices_i = 3'd3;
    wait_clk(12000);
    // XGA-like, divisor 8, all features with four voices
    mode_i = {1'b1, 1'b1, 3'd5, 2'd2};
    audio_en_i = 1'b1; serial_en_i = 1'b1; voices_i = 3'd4;
    wait_clk(10000);
    finish_run();
  end
endmodule